// File: doc/BRIEF.md
# Inter-Core Doorbell Register Block

This block lets any of eight processor cores raise a directed interrupt toward any other core. Each target core owns a generation register and an acknowledgement register. A sender writes a pattern of source-identifier flags into the target's generation register, and sets the ring bit to fire an interrupt. The receiver reads the register to learn which message types are pending. It then writes ones to the matching bits of its acknowledgement register to retire them. Flags are sticky: a write sets the flags it carries and never erases flags that another sender left behind.

The generation and acknowledgement registers are write-protected. A write to either takes effect only after a two-step key sequence has opened the protection. Until then, and after any wrong key, the write is dropped. The block sits on a plain 32-bit register bus with one-cycle registered read data. It drives one interrupt pulse line per core.

Top module: `core_doorbell`

## Requirements
- R1: After reset all source flags read as zero, every interrupt output is low, and the write protection is closed.
- R2: The protection opens only when 0x83E70B13 is written to the first key word (offset 0x038) and then 0x95A4F1E0 is written to the second key word (offset 0x03C).
- R3: Writing any other value to either key word closes the protection. Writing the correct second key without the correct first key before it leaves the protection closed.
- R4: While the protection is closed, writes to generation and acknowledgement registers change no flag and produce no interrupt.
- R5: An accepted write to the generation register of core c (offset 0x240 + 4*c) with bit 0 set drives irq[c] high for exactly one cycle, in the cycle after the write. No other irq bit rises.
- R6: In an accepted generation write, each 1 in bits 31:4 sets the matching source flag. Each 0 leaves that flag as it was, so flags from several writes accumulate.
- R7: In an accepted write to the acknowledgement register of core c (offset 0x280 + 4*c), each 1 in bits 31:4 clears the matching flag of core c. Each 0 leaves that flag unchanged. No interrupt results.
- R8: A read of a generation register returns that core's flags in bits 31:4, with bits 3:0 as zero. Read data appears on rdata in the cycle after rd_en and holds until the next read.
- R9: A read of an acknowledgement register returns the same flag contents as the generation register of the same core.
- R10: An accepted generation write with bit 0 clear updates the flags but raises no interrupt.
- R11: Reads of the key words or of unmapped offsets return zero. Writes to unmapped offsets change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 8 | Per-core interrupt pulses |

## Verification
The bench builds the block with its default parameters: eight cores, 28 flag bits and a 12-bit offset space. This is small enough to sweep every core's generation and acknowledgement slot, and to walk a single flag through all 28 positions. With this size, the one-hot property of the interrupt vector and the per-core routing can be checked for every target. The lock sequence is driven through correct, wrong-first-key, wrong-second-key and out-of-order orders. Each order is followed by a probe write whose effect is read back.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;
endpackage

// File: rtl/db_keylock.sv
module db_keylock
  import doorbell_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          DW       = 32,
  parameter logic [11:0] KEY0_OFS = 12'h038,
  parameter logic [11:0] KEY1_OFS = 12'h03C,
  parameter logic [31:0] KEY0_VAL = 32'h83E7_0B13,
  parameter logic [31:0] KEY1_VAL = 32'h95A4_F1E0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          unlocked
);
  lock_state_e state_q, state_d;
  logic hit0, hit1, good0, good1;

  assign hit0  = wr_en && (addr == AW'(KEY0_OFS));
  assign hit1  = wr_en && (addr == AW'(KEY1_OFS));
  assign good0 = (wdata == DW'(KEY0_VAL));
  assign good1 = (wdata == DW'(KEY1_VAL));

  always_comb begin
    state_d = state_q;
    if (hit0) begin
      state_d = good0 ? LK_ARMED : LK_CLOSED;
    end else if (hit1) begin
      if (!good1)
        state_d = LK_CLOSED;
      else if (state_q == LK_ARMED || state_q == LK_OPEN)
        state_d = LK_OPEN;
      else
        state_d = LK_CLOSED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_CLOSED;
    else     state_q <= state_d;
  end

  assign unlocked = (state_q == LK_OPEN);

  // Opening requires the correct second key in the previous cycle
  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !$past(unlocked)) |->
      ($past(wr_en) && $past(addr) == AW'(KEY1_OFS) && $past(wdata) == DW'(KEY1_VAL)));

  // A wrong key value closes the protection
  assert_bad_key_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == AW'(KEY0_OFS) || addr == AW'(KEY1_OFS)) &&
     wdata != DW'(KEY0_VAL) && wdata != DW'(KEY1_VAL)) |=> !unlocked);
endmodule

// File: rtl/db_decode.sv
module db_decode #(
  parameter int          AW       = 12,
  parameter int          NC       = 8,
  parameter logic [11:0] GEN_BASE = 12'h240,
  parameter logic [11:0] ACK_BASE = 12'h280
) (
  input  logic          wr_en,
  input  logic          unlocked,
  input  logic [AW-1:0] addr,
  output logic [NC-1:0] gen_hit,
  output logic [NC-1:0] ack_hit,
  output logic [NC-1:0] gen_we,
  output logic [NC-1:0] ack_we
);
  localparam int STRIDE = 4;

  for (genvar c = 0; c < NC; c++) begin : g_slot
    assign gen_hit[c] = (addr == AW'(GEN_BASE) + AW'(c * STRIDE));
    assign ack_hit[c] = (addr == AW'(ACK_BASE) + AW'(c * STRIDE));
    assign gen_we[c]  = wr_en && unlocked && gen_hit[c];
    assign ack_we[c]  = wr_en && unlocked && ack_hit[c];
  end
endmodule

// File: rtl/db_flag_slot.sv
module db_flag_slot #(
  parameter int FW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [FW-1:0] set_bits,
  input  logic [FW-1:0] clr_bits,
  input  logic          ring,
  output logic [FW-1:0] flags,
  output logic          irq
);
  logic [FW-1:0] next_flags;

  always_comb begin
    next_flags = flags;
    if (clr_we) next_flags = next_flags & ~clr_bits;
    if (set_we) next_flags = next_flags | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= next_flags;
      irq   <= set_we && ring;
    end
  end

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(flags));

  assert_flags_set_R6: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((flags & $past(set_bits)) == $past(set_bits)));

  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((flags & $past(clr_bits)) == '0));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(set_we) && $past(ring)));
endmodule

// File: rtl/core_doorbell.sv
module core_doorbell #(
  parameter int          NC       = 8,
  parameter int          AW       = 12,
  parameter int          DW       = 32,
  parameter int          FLAG_LSB = 4,
  parameter logic [11:0] GEN_BASE = 12'h240,
  parameter logic [11:0] ACK_BASE = 12'h280,
  parameter logic [11:0] KEY0_OFS = 12'h038,
  parameter logic [11:0] KEY1_OFS = 12'h03C,
  parameter logic [31:0] KEY0_VAL = 32'h83E7_0B13,
  parameter logic [31:0] KEY1_VAL = 32'h95A4_F1E0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic [NC-1:0] irq
);
  localparam int FW = DW - FLAG_LSB;

  logic              lock_open;
  logic [NC-1:0]     gen_hit, ack_hit, gen_we, ack_we;
  logic [NC-1:0][FW-1:0] flag_q;
  logic [DW-1:0]     rd_mux;

  db_keylock #(
    .AW(AW), .DW(DW), .KEY0_OFS(KEY0_OFS), .KEY1_OFS(KEY1_OFS),
    .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
  ) u_lock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .unlocked(lock_open)
  );

  db_decode #(
    .AW(AW), .NC(NC), .GEN_BASE(GEN_BASE), .ACK_BASE(ACK_BASE)
  ) u_dec (
    .wr_en(wr_en), .unlocked(lock_open), .addr(addr),
    .gen_hit(gen_hit), .ack_hit(ack_hit), .gen_we(gen_we), .ack_we(ack_we)
  );

  for (genvar c = 0; c < NC; c++) begin : g_core
    db_flag_slot #(.FW(FW)) u_slot (
      .clk(clk), .rst(rst),
      .set_we(gen_we[c]), .clr_we(ack_we[c]),
      .set_bits(wdata[DW-1:FLAG_LSB]), .clr_bits(wdata[DW-1:FLAG_LSB]),
      .ring(wdata[0]),
      .flags(flag_q[c]), .irq(irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NC; c++) begin
      if (gen_hit[c] || ack_hit[c])
        rd_mux = {flag_q[c], {FLAG_LSB{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_irq_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));

  assert_locked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !lock_open |=> (irq == '0));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_core_doorbell.sv
module sim_core_doorbell;
  localparam logic [11:0] GEN = 12'h240, ACK = 12'h280, K0A = 12'h038, K1A = 12'h03C;
  localparam logic [31:0] K0 = 32'h83E7_0B13, K1 = 32'h95A4_F1E0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic [7:0] irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  core_doorbell u0 (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic unlock();
    wr(K0A, K0);
    wr(K1A, K1);
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int c = 0; c < 8; c++) begin
      rd(GEN + 12'(4 * c), v);
      chk(v == model[c], req, v, model[c]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 8; c++) model[c] = '0;
  endtask

  initial begin
    logic [31:0] v, pat;
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk(irq == 8'h00, "R1 irq low", {24'h0, irq}, 32'h0);
    check_all("R1 flags zero");
    // R1/R4: closed after reset, writes dropped
    wr(GEN + 12'h8, 32'hFFFF_FFF1);
    chk(irq == 8'h00, "R4 locked gen no irq", {24'h0, irq}, 32'h0);
    rd(GEN + 12'h8, v);
    chk(v == 32'h0, "R4 locked gen ignored", v, 32'h0);
    // R3: second key alone keeps it closed
    wr(K1A, K1);
    wr(GEN + 12'h8, 32'h0000_0011);
    chk(irq == 8'h00, "R3 key1 alone no irq", {24'h0, irq}, 32'h0);
    // R3: correct first key, wrong second key
    wr(K0A, K0); wr(K1A, 32'h1234_5678);
    wr(GEN + 12'h8, 32'h0000_0011);
    check_all("R3 wrong key1 closed");
    // R2: proper sequence opens
    unlock();
    wr(GEN + 12'hC, 32'h0000_0011);
    model[3] = 32'h10;
    chk(irq == 8'h08, "R2 open irq core3", {24'h0, irq}, 32'h08);
    @(negedge clk);
    chk(irq == 8'h00, "R5 pulse one cycle", {24'h0, irq}, 32'h0);
    check_all("R2 write accepted");
    // R3: wrong first key closes
    wr(K0A, 32'h0);
    wr(GEN + 12'hC, 32'hF000_0001);
    chk(irq == 8'h00, "R3 closed by key0 no irq", {24'h0, irq}, 32'h0);
    check_all("R3 closed by key0");
    // R3: wrong second key while open closes
    unlock(); wr(K1A, 32'hDEAD_BEEF);
    wr(GEN, 32'hF000_0001);
    check_all("R3 closed by key1");
    // R5/R6/R8/R9: sweep every core
    unlock();
    for (int c = 0; c < 8; c++) begin
      pat = (32'h0111_1110 * (c + 1)) & 32'hFFFF_FFF0;
      wr(GEN + 12'(4 * c), pat | 32'h1);
      model[c] = model[c] | pat;
      chk(irq == 8'(1 << c), "R5 irq routed", {24'h0, irq}, 32'(1 << c));
      @(negedge clk);
      chk(irq == 8'h00, "R5 irq cleared", {24'h0, irq}, 32'h0);
      rd(GEN + 12'(4 * c), v);
      chk(v == model[c], "R8 gen readback", v, model[c]);
      rd(ACK + 12'(4 * c), v);
      chk(v == model[c], "R9 ack mirrors gen", v, model[c]);
    end
    check_all("R6 cores independent");
    // R6/R10: walk one flag through every position, no ring
    for (int b = 4; b < 32; b++) begin
      wr(GEN + 12'h14, 32'(1) << b);
      model[5] = model[5] | (32'(1) << b);
      chk(irq == 8'h00, "R10 no ring no irq", {24'h0, irq}, 32'h0);
      rd(GEN + 12'h14, v);
      chk(v == model[5], "R6 accumulate", v, model[5]);
    end
    // R7: acknowledge clears only ones
    wr(ACK + 12'h14, 32'hAAAA_AAAF);
    model[5] = model[5] & ~32'hAAAA_AAA0;
    chk(irq == 8'h00, "R7 ack no irq", {24'h0, irq}, 32'h0);
    rd(GEN + 12'h14, v);
    chk(v == model[5], "R7 ack clears ones", v, model[5]);
    wr(ACK + 12'h14, 32'h0000_000F);
    check_all("R7 zero ack no change");
    wr(ACK + 12'h4, 32'hFFFF_FFF0);
    model[1] = '0;
    check_all("R7 full ack");
    // R11: keys and unmapped read zero, unmapped writes harmless
    rd(K0A, v);  chk(v == 32'h0, "R11 key0 read", v, 32'h0);
    rd(K1A, v);  chk(v == 32'h0, "R11 key1 read", v, 32'h0);
    rd(12'h100, v); chk(v == 32'h0, "R11 unmapped read", v, 32'h0);
    wr(12'h242, 32'hFFFF_FFF1);
    chk(irq == 8'h00, "R11 misaligned no irq", {24'h0, irq}, 32'h0);
    wr(12'h100, 32'hFFFF_FFF1);
    check_all("R11 unmapped write");
    // R4: acknowledge while closed
    wr(K0A, 32'h1);
    wr(ACK + 12'h14, 32'hFFFF_FFF0);
    check_all("R4 locked ack ignored");
    // R1: reset mid-run closes lock and clears flags
    do_reset();
    check_all("R1 rerun reset");
    wr(GEN, 32'h0000_0011);
    chk(irq == 8'h00, "R1 locked after reset", {24'h0, irq}, 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule